// File: doc/BRIEF.md
# Processor Sleep-State Sequencer

This block decides the clock state of a single processor core. Software puts the core to sleep by reading one of two level registers. A halt indication gives the shallowest sleep. Any interrupt or bus-master request brings the core back to the running state. The deepest state is granted only while bus-master arbitration has been disabled through a small write port. The same write port clears a sticky flag that records bus-master activity.

The current state is given as a 2-bit code. A clock-gate enable drops in the very cycle in which a level-register read is accepted, so the core never runs another cycle after the read. While the core is running, an optional duty-cycle throttle can gate the clock for part of every period.

Top module: `cpu_cstate_seq`

## Requirements
- R1: `state_o` encodes 0 = running (C0), 1 = halted (C1), 2 = stopped (C2), 3 = deep-stopped (C3). After reset `state_o` is 0, `clk_en_o` is 1, and `arb_dis_o` and `bm_sts_o` are 0.
- R2: In C0, `halt_i` with no read strobe moves the core to C1 at the next clock edge.
- R3: In C0, a `lvl2_rd_i` strobe without `lvl3_rd_i` moves the core to C2 at the next clock edge.
- R4: In C0, a `lvl3_rd_i` strobe moves the core to C3 when the arbiter-disable bit is 1, and to C2 when it is 0. If both strobes are high, the level-3 strobe wins.
- R5: `clk_en_o` is 0 combinationally in the same cycle as a read strobe accepted in C0. It is 0 in every state other than C0.
- R6: In C1, C2 or C3, `irq_i` or `bm_req_i` returns the core to C0 at the next clock edge.
- R7: `bm_sts_o` is 1 from the edge after any cycle with `bm_req_i` = 1, and it stays set. A cycle with `cfg_wr_i` = 1 and `cfg_bm_clr_i` = 1 clears it, unless `bm_req_i` is 1 in that same cycle, in which case it stays 1.
- R8: A cycle with `cfg_wr_i` = 1 loads `cfg_arb_dis_i` into the arbiter-disable bit. `arb_dis_o` shows that bit in every state.
- R9: `rd_data_o` is all zeros at all times, including during level-register reads.
- R10: Read strobes that arrive while the core is in C1, C2 or C3 do not change the state.
- R11: In C0 with `thr_en_i` = 1 and `thr_duty_i` = d, where d is not 0, `clk_en_o` is 1 for exactly d cycles of every 2^DUTY_W consecutive cycles (8 by default). With d = 0, or with `thr_en_i` = 0, `clk_en_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| halt_i | input | 1 | Core halt indication |
| irq_i | input | 1 | Interrupt request (wake) |
| bm_req_i | input | 1 | Bus-master access (wake, sets status) |
| lvl2_rd_i | input | 1 | Read strobe of the level-2 register |
| lvl3_rd_i | input | 1 | Read strobe of the level-3 register |
| rd_data_o | output | RD_W | Read data of the level registers (zero) |
| cfg_wr_i | input | 1 | Write strobe for the control bits |
| cfg_arb_dis_i | input | 1 | Arbiter-disable value to write |
| cfg_bm_clr_i | input | 1 | Write 1 to clear the bus-master status |
| thr_en_i | input | 1 | Throttle enable |
| thr_duty_i | input | DUTY_W | Throttle duty (enabled cycles per period) |
| state_o | output | 2 | Current clock state code |
| clk_en_o | output | 1 | Core clock-gate enable |
| arb_dis_o | output | 1 | Bus-arbiter disable |
| bm_sts_o | output | 1 | Sticky bus-master status |

## Verification
A state change is due one clock edge after its strobe. The bench drives every input on the falling edge and reads `state_o` 1 ns after the next rising edge. The drop of `clk_en_o` on a read is combinational, so it is checked 1 ns after the falling edge that raises the strobe, before any rising edge. The status and arbiter-disable bits also register at the next rising edge and are sampled the same way. The throttle is checked by counting `clk_en_o` once per cycle, between edges, over a full period.

// File: rtl/cstate_pkg.sv
package cstate_pkg;

   typedef enum logic [1:0] {
      CS_RUN  = 2'd0,
      CS_HALT = 2'd1,
      CS_STOP = 2'd2,
      CS_DEEP = 2'd3
   } cstate_e;

   localparam int unsigned CS_CODE_W = 2;

endpackage

// File: rtl/cstate_fsm.sv
module cstate_fsm
   import cstate_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    halt_i,
   input  logic    irq_i,
   input  logic    bm_req_i,
   input  logic    lvl2_rd_i,
   input  logic    lvl3_rd_i,
   input  logic    arb_dis_i,
   output cstate_e state_o,
   output logic    entry_o
);

   cstate_e cur_q;
   cstate_e nxt;
   logic    wake;

   assign wake = irq_i | bm_req_i;

   always_comb begin
      nxt     = cur_q;
      entry_o = 1'b0;
      unique case (cur_q)
         CS_RUN: begin
            if (lvl3_rd_i) begin
               entry_o = 1'b1;
               nxt     = arb_dis_i ? CS_DEEP : CS_STOP;
            end else if (lvl2_rd_i) begin
               entry_o = 1'b1;
               nxt     = CS_STOP;
            end else if (halt_i) begin
               nxt = CS_HALT;
            end
         end
         CS_HALT, CS_STOP, CS_DEEP: begin
            if (wake) nxt = CS_RUN;
         end
         default: nxt = CS_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cur_q <= CS_RUN;
      else        cur_q <= nxt;
   end

   assign state_o = cur_q;

endmodule

// File: rtl/cstate_ctrl_bits.sv
module cstate_ctrl_bits (
   input  logic clk,
   input  logic rst_n,
   input  logic cfg_wr_i,
   input  logic cfg_arb_dis_i,
   input  logic cfg_bm_clr_i,
   input  logic bm_req_i,
   output logic arb_dis_o,
   output logic bm_sts_o
);

   logic arb_q;
   logic bm_q;
   logic clr;

   assign clr = cfg_wr_i & cfg_bm_clr_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arb_q <= 1'b0;
         bm_q  <= 1'b0;
      end else begin
         if (cfg_wr_i) arb_q <= cfg_arb_dis_i;
         if (bm_req_i)  bm_q <= 1'b1;
         else if (clr)  bm_q <= 1'b0;
      end
   end

   assign arb_dis_o = arb_q;
   assign bm_sts_o  = bm_q;

endmodule

// File: rtl/cstate_throttle.sv
module cstate_throttle #(
   parameter int unsigned DUTY_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active_i,
   input  logic [DUTY_W-1:0] duty_i,
   output logic              gate_o
);

   logic [DUTY_W-1:0] phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         phase_q <= '0;
      else if (!active_i) phase_q <= '0;
      else                phase_q <= phase_q + 1'b1;
   end

   assign gate_o = !active_i || (duty_i == '0) || (phase_q < duty_i);

endmodule

// File: rtl/cpu_cstate_seq.sv
module cpu_cstate_seq
   import cstate_pkg::*;
#(
   parameter int unsigned RD_W         = 32,
   parameter int unsigned DUTY_W       = 3,
   parameter bit          HAS_THROTTLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              halt_i,
   input  logic              irq_i,
   input  logic              bm_req_i,
   input  logic              lvl2_rd_i,
   input  logic              lvl3_rd_i,
   output logic [RD_W-1:0]   rd_data_o,
   input  logic              cfg_wr_i,
   input  logic              cfg_arb_dis_i,
   input  logic              cfg_bm_clr_i,
   input  logic              thr_en_i,
   input  logic [DUTY_W-1:0] thr_duty_i,
   output logic [1:0]        state_o,
   output logic              clk_en_o,
   output logic              arb_dis_o,
   output logic              bm_sts_o
);

   localparam int unsigned THR_PERIOD = 1 << DUTY_W;

   if (RD_W < 1) begin : g_bad_rd_w
      $error("cpu_cstate_seq: RD_W must be at least 1");
   end
   if (DUTY_W < 1 || DUTY_W > 8) begin : g_bad_duty_w
      $error("cpu_cstate_seq: DUTY_W must be 1..8");
   end
   if (THR_PERIOD < 2) begin : g_bad_period
      $error("cpu_cstate_seq: throttle period too short");
   end

   cstate_e cur_state;
   logic    entry;
   logic    arb_bit;
   logic    thr_gate;
   logic    running;

   cstate_ctrl_bits u_bits (
      .clk           (clk),
      .rst_n         (rst_n),
      .cfg_wr_i      (cfg_wr_i),
      .cfg_arb_dis_i (cfg_arb_dis_i),
      .cfg_bm_clr_i  (cfg_bm_clr_i),
      .bm_req_i      (bm_req_i),
      .arb_dis_o     (arb_bit),
      .bm_sts_o      (bm_sts_o)
   );

   cstate_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .halt_i    (halt_i),
      .irq_i     (irq_i),
      .bm_req_i  (bm_req_i),
      .lvl2_rd_i (lvl2_rd_i),
      .lvl3_rd_i (lvl3_rd_i),
      .arb_dis_i (arb_bit),
      .state_o   (cur_state),
      .entry_o   (entry)
   );

   assign running = (cur_state == CS_RUN);

   if (HAS_THROTTLE) begin : g_thr
      cstate_throttle #(.DUTY_W(DUTY_W)) u_thr (
         .clk      (clk),
         .rst_n    (rst_n),
         .active_i (running & thr_en_i),
         .duty_i   (thr_duty_i),
         .gate_o   (thr_gate)
      );
   end else begin : g_no_thr
      assign thr_gate = 1'b1;
   end

   assign state_o   = cur_state;
   assign clk_en_o  = running & ~entry & thr_gate;
   assign arb_dis_o = arb_bit;
   assign rd_data_o = '0;

endmodule

// File: rtl/cpu_cstate_seq_chk.sv
module cpu_cstate_seq_chk #(
   parameter int unsigned RD_W   = 32,
   parameter int unsigned DUTY_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              halt_i,
   input logic              irq_i,
   input logic              bm_req_i,
   input logic              lvl2_rd_i,
   input logic              lvl3_rd_i,
   input logic [RD_W-1:0]   rd_data_o,
   input logic              cfg_wr_i,
   input logic              cfg_arb_dis_i,
   input logic              cfg_bm_clr_i,
   input logic [1:0]        state_o,
   input logic              clk_en_o,
   input logic              arb_dis_o,
   input logic              bm_sts_o
);

   AST_HALT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd0 && halt_i && !lvl2_rd_i && !lvl3_rd_i) |=> state_o == 2'd1); // R2

   AST_LVL2_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd0 && lvl2_rd_i && !lvl3_rd_i) |=> state_o == 2'd2); // R3

   AST_DEEP_NEEDS_ARB: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd0 && lvl3_rd_i) |=> state_o == ($past(arb_dis_o) ? 2'd3 : 2'd2)); // R4

   AST_GATE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd0 && (lvl2_rd_i || lvl3_rd_i)) |-> !clk_en_o); // R5

   AST_GATE_ONLY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o != 2'd0) |-> !clk_en_o); // R5

   AST_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o != 2'd0 && (irq_i || bm_req_i)) |=> state_o == 2'd0); // R6

   AST_BM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      bm_req_i |=> bm_sts_o); // R7

   AST_BM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (bm_sts_o && !(cfg_wr_i && cfg_bm_clr_i)) |=> bm_sts_o); // R7

   AST_ARB_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr_i |=> arb_dis_o == $past(cfg_arb_dis_i)); // R8

   AST_ARB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_wr_i |=> $stable(arb_dis_o)); // R8

   AST_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl2_rd_i || lvl3_rd_i) |-> rd_data_o == '0); // R9

   AST_SLEEP_IGNORES_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o != 2'd0 && !irq_i && !bm_req_i) |=> $stable(state_o)); // R10

endmodule

bind cpu_cstate_seq cpu_cstate_seq_chk #(.RD_W(RD_W), .DUTY_W(DUTY_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .halt_i        (halt_i),
   .irq_i         (irq_i),
   .bm_req_i      (bm_req_i),
   .lvl2_rd_i     (lvl2_rd_i),
   .lvl3_rd_i     (lvl3_rd_i),
   .rd_data_o     (rd_data_o),
   .cfg_wr_i      (cfg_wr_i),
   .cfg_arb_dis_i (cfg_arb_dis_i),
   .cfg_bm_clr_i  (cfg_bm_clr_i),
   .state_o       (state_o),
   .clk_en_o      (clk_en_o),
   .arb_dis_o     (arb_dis_o),
   .bm_sts_o      (bm_sts_o)
);

// File: tb/cpu_cstate_seq_tb_top.sv
`timescale 1ns/1ps
module cpu_cstate_seq_tb_top;

   localparam int unsigned RD_W   = 32;
   localparam int unsigned DUTY_W = 3;
   localparam int unsigned PERIOD = 1 << DUTY_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              halt_i = 1'b0;
   logic              irq_i = 1'b0;
   logic              bm_req_i = 1'b0;
   logic              lvl2_rd_i = 1'b0;
   logic              lvl3_rd_i = 1'b0;
   logic [RD_W-1:0]   rd_data_o;
   logic              cfg_wr_i = 1'b0;
   logic              cfg_arb_dis_i = 1'b0;
   logic              cfg_bm_clr_i = 1'b0;
   logic              thr_en_i = 1'b0;
   logic [DUTY_W-1:0] thr_duty_i = '0;
   logic [1:0]        state_o;
   logic              clk_en_o;
   logic              arb_dis_o;
   logic              bm_sts_o;

   int errors = 0;
   int checks = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   cpu_cstate_seq #(.RD_W(RD_W), .DUTY_W(DUTY_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .halt_i(halt_i), .irq_i(irq_i), .bm_req_i(bm_req_i),
      .lvl2_rd_i(lvl2_rd_i), .lvl3_rd_i(lvl3_rd_i), .rd_data_o(rd_data_o),
      .cfg_wr_i(cfg_wr_i), .cfg_arb_dis_i(cfg_arb_dis_i), .cfg_bm_clr_i(cfg_bm_clr_i),
      .thr_en_i(thr_en_i), .thr_duty_i(thr_duty_i), .state_o(state_o),
      .clk_en_o(clk_en_o), .arb_dis_o(arb_dis_o), .bm_sts_o(bm_sts_o)
   );

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=below 20000 cycles", cycles);
         summary();
         $finish;
      end
   end

   task automatic edge_after();
      @(posedge clk); #1;
   endtask

   task automatic release_all();
      @(negedge clk);
      halt_i = 0; irq_i = 0; bm_req_i = 0; lvl2_rd_i = 0; lvl3_rd_i = 0;
      cfg_wr_i = 0; cfg_bm_clr_i = 0;
   endtask

   task automatic write_arb(input logic v);
      @(negedge clk); cfg_wr_i = 1; cfg_arb_dis_i = v; cfg_bm_clr_i = 0;
      edge_after();
      chk("R8 arb_dis after write", arb_dis_o, v);
      release_all();
   endtask

   task automatic wake_irq(input string req);
      @(negedge clk); irq_i = 1;
      edge_after();
      chk(req, state_o, 0);
      release_all();
   endtask

   task automatic t_reset();
      chk("R1 reset state", state_o, 0);
      chk("R1 reset clk_en", clk_en_o, 1);
      chk("R1 reset arb_dis", arb_dis_o, 0);
      chk("R1 reset bm_sts", bm_sts_o, 0);
   endtask

   task automatic t_halt();
      @(negedge clk); halt_i = 1;
      #1 chk("R2 halt does not gate before edge", clk_en_o, 1);
      edge_after();
      chk("R2 halt enters C1", state_o, 1);
      chk("R5 clk_en low in C1", clk_en_o, 0);
      release_all();
      @(negedge clk); bm_req_i = 1;
      edge_after();
      chk("R6 bus-master wakes C1", state_o, 0);
      release_all();
   endtask

   task automatic t_lvl2();
      @(negedge clk); lvl2_rd_i = 1;
      #1 chk("R5 clk_en drops on level-2 read", clk_en_o, 0);
      chk("R9 read data zero", rd_data_o, 0);
      edge_after();
      chk("R3 level-2 read enters C2", state_o, 2);
      release_all();
      @(negedge clk); lvl3_rd_i = 1;
      edge_after();
      chk("R10 level-3 read in C2 ignored", state_o, 2);
      release_all();
      wake_irq("R6 irq wakes C2");
   endtask

   task automatic t_lvl3_noarb();
      @(negedge clk); lvl3_rd_i = 1;
      #1 chk("R5 clk_en drops on level-3 read", clk_en_o, 0);
      edge_after();
      chk("R4 level-3 read without arb_dis gives C2", state_o, 2);
      release_all();
      wake_irq("R6 irq wakes C2 after level-3");
   endtask

   task automatic t_lvl3_arb();
      write_arb(1);
      @(negedge clk); lvl3_rd_i = 1;
      #1 chk("R9 read data zero on level-3", rd_data_o, 0);
      edge_after();
      chk("R4 level-3 read with arb_dis gives C3", state_o, 3);
      chk("R8 arb_dis mirrored in C3", arb_dis_o, 1);
      chk("R5 clk_en low in C3", clk_en_o, 0);
      release_all();
      @(negedge clk); lvl2_rd_i = 1; halt_i = 1;
      edge_after();
      chk("R10 level-2 read in C3 ignored", state_o, 3);
      release_all();
      wake_irq("R6 irq wakes C3");
      @(negedge clk); lvl2_rd_i = 1; lvl3_rd_i = 1;
      edge_after();
      chk("R4 level-3 wins over level-2", state_o, 3);
      release_all();
      @(negedge clk); bm_req_i = 1;
      edge_after();
      chk("R6 bus-master wakes C3", state_o, 0);
      release_all();
      write_arb(0);
   endtask

   task automatic t_bm_status();
      chk("R7 bm_sts set by earlier access", bm_sts_o, 1);
      @(negedge clk); cfg_wr_i = 1; cfg_bm_clr_i = 1; cfg_arb_dis_i = 0; bm_req_i = 1;
      edge_after();
      chk("R7 set wins over clear", bm_sts_o, 1);
      chk("R6 bus-master in C0 keeps C0", state_o, 0);
      release_all();
      repeat (2) edge_after();
      chk("R7 bm_sts sticky", bm_sts_o, 1);
      @(negedge clk); cfg_wr_i = 1; cfg_bm_clr_i = 1; cfg_arb_dis_i = 0;
      edge_after();
      chk("R7 write-one clears bm_sts", bm_sts_o, 0);
      release_all();
      @(negedge clk); cfg_wr_i = 1; cfg_bm_clr_i = 0; cfg_arb_dis_i = 1;
      edge_after();
      chk("R8 write sets arb_dis", arb_dis_o, 1);
      release_all();
      write_arb(0);
   endtask

   task automatic count_window(input string req, input int exp);
      int ones = 0;
      for (int i = 0; i < PERIOD; i++) begin
         @(negedge clk); #1;
         if (clk_en_o) ones++;
      end
      chk(req, ones, exp);
   endtask

   task automatic t_throttle();
      @(negedge clk); thr_duty_i = 3'd3; thr_en_i = 1;
      count_window("R11 duty 3 gives 3 enabled cycles", 3);
      count_window("R11 duty 3 repeats each period", 3);
      @(negedge clk); thr_duty_i = 3'd7;
      count_window("R11 duty 7 gives 7 enabled cycles", 7);
      @(negedge clk); thr_duty_i = 3'd0;
      count_window("R11 duty 0 is full rate", PERIOD);
      @(negedge clk); thr_duty_i = 3'd5; thr_en_i = 0;
      count_window("R11 throttle disabled is full rate", PERIOD);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      edge_after();
      t_reset();
      t_halt();
      t_lvl2();
      t_lvl3_noarb();
      t_lvl3_arb();
      t_bm_status();
      t_throttle();
      done = 1'b1;
      summary();
      $finish;
   end

endmodule